// File: doc/BRIEF.md
# Parallel Converter Bus Host Sequencer

This block lets on-chip logic talk to an external 12-bit parallel digital-to-analog converter. A single command port, guarded by a valid/ready handshake, takes write, read-back, load and reset requests. For each accepted request the sequencer plays out the matching pin waveform: chip select, read/write direction, load strobe, converter reset and reset-level select. It also controls when the host drives the shared data bus.

Every phase lasts a parameterised number of clock cycles, so pulse widths, setup and hold margins, read access delay and bus turnaround can be sized for any clock frequency. A read samples the bus a set number of cycles after chip select falls and returns the word on a response port as a one-cycle pulse. Writing the input register and updating the converter output are separate commands, so a new value can be staged early and applied later with a load. A fused write-then-load command is also provided.

Top module: `pbus_host_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no command given, `dac_cs_n`, `dac_ld_n`, `dac_rst_n` and `dac_rw` are high, `bus_oe` is low, `cmd_ready` is high, `dac_rst_sel` is 0 and `rsp_valid` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until the final interval of that command has run out. Whatever is presented on `cmd_op` and `cmd_data` while `cmd_ready` is low has no effect.
- R3: `cmd_op` encoding: 0 write, 1 read, 2 load, 3 write then load, 4 reset. Codes 5, 6 and 7 are taken and do nothing: all pins stay idle and `cmd_ready` stays high.
- R4: Write. From the cycle after acceptance, `dac_cs_n` and `dac_rw` are both low for T_WR_CS cycles while `bus_oe` is high and `bus_out` carries `cmd_data`. Then `dac_cs_n` is high and `dac_rw` is still low for T_WR_HOLD cycles, with the bus still driven.
- R5: Read. From the cycle after acceptance, `dac_rw` is high and `dac_cs_n` is high for T_RD_SETUP cycles. Then `dac_cs_n` is low for T_RD_CS cycles. `bus_oe` is low throughout.
- R6: `bus_in` is captured at the clock edge that ends the T_RD_SAMPLE-th cycle of `dac_cs_n` low. In the following cycle `rsp_valid` is high for exactly one cycle and `rsp_data` shows the captured word. `rsp_data` holds that word afterwards.
- R7: After `dac_cs_n` rises at the end of a read, `bus_oe` stays low and `cmd_ready` stays low for T_TURN cycles.
- R8: Load. From the cycle after acceptance, `dac_ld_n` is low for T_LOAD cycles while every other pin stays idle.
- R9: Write then load. The full write waveform of R4 is followed directly by the load pulse of R8, and only then does `cmd_ready` return.
- R10: Reset. From the cycle after acceptance, `dac_rst_n` is low for T_RST cycles. In the same cycle `dac_rst_sel` takes `cmd_data[0]` (1 selects mid-scale, 0 zero-scale) and keeps that value until the next reset command.
- R11: `dac_rw` never changes while `dac_cs_n` stays low. At most one of `dac_cs_n`, `dac_ld_n` and `dac_rst_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command may be taken |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 12 | Write word; bit 0 is the reset-level select for reset |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 12 | Word read back from the converter |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_rw | output | 1 | Direction, high read, low write |
| dac_ld_n | output | 1 | Output-register load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_rst_sel | output | 1 | Reset level select, 1 mid-scale |
| bus_out | output | 12 | Host data driven onto the bus |
| bus_oe | output | 1 | Host bus driver enable |
| bus_in | input | 12 | Data seen on the bus |

## Verification
The bench changes `bus_in` on every cycle, so a capture taken one edge early or late returns a different word and shows up as a wrong `rsp_data`. Random codes are presented while the sequencer is busy: a design that peeks at the port mid-transaction would restart or corrupt the write word or the reset select. Back-to-back commands check that ready comes back only after the write hold and the read turnaround; a design that dropped those intervals would start the next chip-select while the bus is still in contention. Unused codes and the fused write-then-load catch decode slips, such as a load that never follows the write or a spurious pulse on an unused code.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam logic [2:0] OP_WRITE  = 3'd0;
  localparam logic [2:0] OP_READ   = 3'd1;
  localparam logic [2:0] OP_LOAD   = 3'd2;
  localparam logic [2:0] OP_WRLOAD = 3'd3;
  localparam logic [2:0] OP_RESET  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_ACT,
    S_WR_HOLD,
    S_RD_SETUP,
    S_RD_ACT,
    S_RD_TURN,
    S_LD_PULSE,
    S_RST_PULSE
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int T_WR_CS    = 5,
  parameter int T_WR_HOLD  = 1,
  parameter int T_RD_SETUP = 1,
  parameter int T_RD_CS    = 20,
  parameter int T_TURN     = 10,
  parameter int T_LOAD     = 5,
  parameter int T_RST      = 5,
  parameter int CW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  output seq_state_e    state_q,
  output seq_state_e    state_d,
  output logic [CW-1:0] cnt_q,
  output logic          accept
);

  logic [CW-1:0] cnt_d;
  logic          ld_after_q, ld_after_d;

  // Length of a phase minus one, loaded on entry and counted down to zero.
  function automatic logic [CW-1:0] span(input seq_state_e s);
    case (s)
      S_WR_ACT:    return CW'(T_WR_CS - 1);
      S_WR_HOLD:   return CW'(T_WR_HOLD - 1);
      S_RD_SETUP:  return CW'(T_RD_SETUP - 1);
      S_RD_ACT:    return CW'(T_RD_CS - 1);
      S_RD_TURN:   return CW'(T_TURN - 1);
      S_LD_PULSE:  return CW'(T_LOAD - 1);
      S_RST_PULSE: return CW'(T_RST - 1);
      default:     return '0;
    endcase
  endfunction

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ld_after_d = ld_after_q;
    accept     = 1'b0;
    if (state_q == S_IDLE) begin
      if (cmd_valid) begin
        accept = 1'b1;
        case (cmd_op)
          OP_WRITE:  begin state_d = S_WR_ACT; ld_after_d = 1'b0; end
          OP_WRLOAD: begin state_d = S_WR_ACT; ld_after_d = 1'b1; end
          OP_READ:   state_d = S_RD_SETUP;
          OP_LOAD:   state_d = S_LD_PULSE;
          OP_RESET:  state_d = S_RST_PULSE;
          default:   state_d = S_IDLE;
        endcase
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      case (state_q)
        S_WR_ACT:   state_d = S_WR_HOLD;
        S_WR_HOLD:  state_d = ld_after_q ? S_LD_PULSE : S_IDLE;
        S_RD_SETUP: state_d = S_RD_ACT;
        S_RD_ACT:   state_d = S_RD_TURN;
        default:    state_d = S_IDLE;
      endcase
    end
    if (state_d != state_q) cnt_d = span(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      ld_after_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      ld_after_q <= ld_after_d;
    end
  end

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_d,
  input  logic          accept,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          dac_cs_n,
  output logic          dac_rw,
  output logic          dac_ld_n,
  output logic          dac_rst_n,
  output logic          dac_rst_sel,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);

  logic cs_n_d, rw_d, ld_n_d, rst_n_d, oe_d;
  logic data_en, sel_en;

  always_comb begin
    cs_n_d  = !(state_d == S_WR_ACT || state_d == S_RD_ACT);
    rw_d    = !(state_d == S_WR_ACT || state_d == S_WR_HOLD);
    oe_d    = (state_d == S_WR_ACT || state_d == S_WR_HOLD);
    ld_n_d  = (state_d != S_LD_PULSE);
    rst_n_d = (state_d != S_RST_PULSE);
    data_en = accept && (cmd_op == OP_WRITE || cmd_op == OP_WRLOAD);
    sel_en  = accept && (cmd_op == OP_RESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_cs_n  <= 1'b1;
      dac_rw    <= 1'b1;
      dac_ld_n  <= 1'b1;
      dac_rst_n <= 1'b1;
      bus_oe    <= 1'b0;
    end else begin
      dac_cs_n  <= cs_n_d;
      dac_rw    <= rw_d;
      dac_ld_n  <= ld_n_d;
      dac_rst_n <= rst_n_d;
      bus_oe    <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_out <= '0;
    else if (data_en) bus_out <= cmd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_rst_sel <= 1'b0;
    else if (sel_en) dac_rst_sel <= cmd_data[0];
  end

endmodule

// File: rtl/pbus_rdcap.sv
module pbus_rdcap
  import pbus_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CW          = 5,
  parameter int T_RD_CS     = 20,
  parameter int T_RD_SAMPLE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [DW-1:0] bus_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  localparam logic [CW-1:0] CAP_AT = CW'(T_RD_CS - T_RD_SAMPLE);

  logic cap_en;

  always_comb cap_en = (state_q == S_RD_ACT) && (cnt_q == CAP_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else rsp_valid <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_data <= '0;
    else if (cap_en) rsp_data <= bus_in;
  end

endmodule

// File: rtl/pbus_host_ctrl.sv
module pbus_host_ctrl
  import pbus_pkg::*;
#(
  parameter int DW          = 12,
  parameter int T_WR_CS     = 5,
  parameter int T_WR_HOLD   = 1,
  parameter int T_RD_SETUP  = 1,
  parameter int T_RD_CS     = 20,
  parameter int T_RD_SAMPLE = 16,
  parameter int T_TURN      = 10,
  parameter int T_LOAD      = 5,
  parameter int T_RST       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          dac_cs_n,
  output logic          dac_rw,
  output logic          dac_ld_n,
  output logic          dac_rst_n,
  output logic          dac_rst_sel,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in
);

  localparam int TMAX = max2(max2(max2(T_WR_CS, T_WR_HOLD), max2(T_RD_SETUP, T_RD_CS)),
                             max2(max2(T_TURN, T_LOAD), T_RST));
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          accept;

  pbus_seq #(
    .T_WR_CS(T_WR_CS), .T_WR_HOLD(T_WR_HOLD), .T_RD_SETUP(T_RD_SETUP),
    .T_RD_CS(T_RD_CS), .T_TURN(T_TURN), .T_LOAD(T_LOAD), .T_RST(T_RST), .CW(CW)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .state_q(state_q), .state_d(state_d), .cnt_q(cnt_q), .accept(accept)
  );

  pbus_pins #(.DW(DW)) i_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .accept(accept),
    .cmd_op(cmd_op), .cmd_data(cmd_data),
    .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_ld_n(dac_ld_n),
    .dac_rst_n(dac_rst_n), .dac_rst_sel(dac_rst_sel),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  pbus_rdcap #(.DW(DW), .CW(CW), .T_RD_CS(T_RD_CS), .T_RD_SAMPLE(T_RD_SAMPLE)) i_rdcap (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .cnt_q(cnt_q),
    .bus_in(bus_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_comb cmd_ready = (state_q == S_IDLE);

endmodule

// File: rtl/pbus_host_ctrl_chk.sv
module pbus_host_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          dac_cs_n,
  input logic          dac_rw,
  input logic          dac_ld_n,
  input logic          dac_rst_n,
  input logic          bus_oe
);

  assert_rw_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_rw));

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dac_cs_n, !dac_ld_n, !dac_rst_n}));

  assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !dac_rw);

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dac_cs_n) && !$past(dac_rw)) |-> (!dac_rw && bus_oe));

  assert_read_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_cs_n) && dac_rw) |-> $past(dac_rw));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n || !dac_ld_n || !dac_rst_n || bus_oe) |-> !cmd_ready);

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dac_cs_n) && $past(dac_rw)) |-> (!cmd_ready && !bus_oe));

endmodule

bind pbus_host_ctrl pbus_host_ctrl_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_ld_n(dac_ld_n),
  .dac_rst_n(dac_rst_n), .bus_oe(bus_oe)
);

// File: tb/test_pbus_host_ctrl.sv
module test_pbus_host_ctrl;

  localparam int WCS = 5, WH = 1, RSU = 1, RCS = 20, SMP = 16, TA = 10, LDW = 5, RSW = 5;
  localparam int NCMD = 16;

  typedef struct {
    logic cs, rw, ld, rs, oe, rv, rdy;
    logic [11:0] bus, rd;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [11:0] cmd_data;
  logic rsp_valid;
  logic [11:0] rsp_data;
  logic dac_cs_n, dac_rw, dac_ld_n, dac_rst_n, dac_rst_sel, bus_oe;
  logic [11:0] bus_out, bus_in;

  always #5 clk = ~clk;

  pbus_host_ctrl #(
    .T_WR_CS(WCS), .T_WR_HOLD(WH), .T_RD_SETUP(RSU), .T_RD_CS(RCS),
    .T_RD_SAMPLE(SMP), .T_TURN(TA), .T_LOAD(LDW), .T_RST(RSW)
  ) i_pbus_host_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_ld_n(dac_ld_n), .dac_rst_n(dac_rst_n),
    .dac_rst_sel(dac_rst_sel), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic sel_m = 1'b0;
  string itag = "R1";
  bit   in_reset = 1'b1;
  int   idx = 0;
  int   ops[NCMD];
  logic [11:0] dats[NCMD];

  function automatic exp_t quiet(input string t, input logic rdy);
    exp_t e;
    e.cs = 1; e.rw = 1; e.ld = 1; e.rs = 1; e.oe = 0; e.rv = 0; e.rdy = rdy;
    e.bus = '0; e.rd = '0; e.tag = t;
    return e;
  endfunction

  task automatic add_write(input logic [11:0] d);
    exp_t e;
    for (int i = 0; i < WCS; i++) begin
      e = quiet("R4", 0); e.cs = 0; e.rw = 0; e.oe = 1; e.bus = d; q.push_back(e);
    end
    for (int i = 0; i < WH; i++) begin
      e = quiet("R4", 0); e.rw = 0; e.oe = 1; e.bus = d; q.push_back(e);
    end
  endtask

  task automatic add_pulse(input bit is_load, input string t);
    exp_t e;
    for (int i = 0; i < (is_load ? LDW : RSW); i++) begin
      e = quiet(t, 0);
      if (is_load) e.ld = 0; else e.rs = 0;
      q.push_back(e);
    end
  endtask

  task automatic add_read(input int c);
    exp_t e;
    int   base;
    base = q.size();
    for (int i = 0; i < RSU; i++) q.push_back(quiet("R5", 0));
    // R11: direction held high through the whole chip-select low window
    for (int i = 0; i < RCS; i++) begin
      e = quiet("R5", 0); e.cs = 0; q.push_back(e);
    end
    for (int i = 0; i < TA; i++) q.push_back(quiet("R7", 0));
    q[base + RSU + SMP].rv  = 1'b1;
    q[base + RSU + SMP].rd  = 12'(c + RSU + SMP);
    q[base + RSU + SMP].tag = "R6";
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    cyc++;
    if (q.size() > 0) e = q.pop_front();
    else e = quiet(itag, 1);
    if (!in_reset) itag = "R2";
    n_cmp++;
    if (dac_cs_n !== e.cs || dac_rw !== e.rw || dac_ld_n !== e.ld || dac_rst_n !== e.rs ||
        bus_oe !== e.oe || rsp_valid !== e.rv || cmd_ready !== e.rdy ||
        (e.oe && bus_out !== e.bus) || (e.rv && rsp_data !== e.rd)) begin
      n_bad++;
      $display("FAIL %s cyc=%0d got cs=%b rw=%b ld=%b rs=%b oe=%b rv=%b rdy=%b bus=%h rd=%h exp cs=%b rw=%b ld=%b rs=%b oe=%b rv=%b rdy=%b bus=%h rd=%h",
               e.tag, cyc, dac_cs_n, dac_rw, dac_ld_n, dac_rst_n, bus_oe, rsp_valid, cmd_ready,
               bus_out, rsp_data, e.cs, e.rw, e.ld, e.rs, e.oe, e.rv, e.rdy, e.bus, e.rd);
    end
    n_cmp++;
    if (dac_rst_sel !== sel_m) begin
      n_bad++;
      $display("FAIL R10 cyc=%0d rst_sel got %b exp %b", cyc, dac_rst_sel, sel_m);
    end
    if (in_reset) begin
      cmd_valid = 1'b0;
    end else if (e.rdy && idx < NCMD) begin
      cmd_valid = (ops[idx] < 8);
      cmd_op    = 3'(ops[idx]);
      cmd_data  = dats[idx];
      case (ops[idx])
        0: add_write(dats[idx]);
        1: add_read(cyc);
        2: add_pulse(1'b1, "R8");
        3: begin add_write(dats[idx]); add_pulse(1'b1, "R9"); end
        4: begin add_pulse(1'b0, "R10"); sel_m = dats[idx][0]; end
        5, 6, 7: itag = "R3";
        default: ;
      endcase
      idx++;
    end else if (!e.rdy) begin
      // R2: junk on the port while busy must be ignored
      cmd_valid = 1'b1;
      cmd_op    = 3'($urandom);
      cmd_data  = 12'($urandom);
    end else begin
      cmd_valid = 1'b0;
    end
    bus_in = cyc[11:0];
  endtask

  initial begin
    ops[0]  = 0; dats[0]  = 12'hABC;
    ops[1]  = 1; dats[1]  = 12'h000;
    ops[2]  = 2; dats[2]  = 12'h000;
    ops[3]  = 3; dats[3]  = 12'h123;
    ops[4]  = 4; dats[4]  = 12'h001;
    ops[5]  = 5; dats[5]  = 12'h000;
    ops[6]  = 8; dats[6]  = 12'h000;
    ops[7]  = 7; dats[7]  = 12'hFFE;
    ops[8]  = 1; dats[8]  = 12'h000;
    ops[9]  = 0; dats[9]  = 12'hFFF;
    ops[10] = 0; dats[10] = 12'h000;
    ops[11] = 4; dats[11] = 12'hFFE;
    ops[12] = 6; dats[12] = 12'h001;
    ops[13] = 1; dats[13] = 12'h000;
    ops[14] = 4; dats[14] = 12'h001;
    ops[15] = 2; dats[15] = 12'h000;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; bus_in = '0;
    for (int i = 0; i < 3; i++) step();   // R1 during reset
    rst_n = 1'b1;
    in_reset = 1'b0;
    itag = "R1";
    while ((idx < NCMD || q.size() > 0) && cyc < 5000) step();
    if (cyc >= 5000) begin
      n_bad++;
      $display("FAIL R2 watchdog expired at cyc=%0d", cyc);
    end
    for (int i = 0; i < 4; i++) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    $display("FAIL R2 watchdog timeout");
    n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule